// File: doc/BRIEF.md
# Paged Address Translator with Usage Marking

This block maps CPU logical addresses in the bottom 4 MB of a 24-bit space onto physical addresses. It uses a page table of 1024 sixteen-bit entries. Logical bits [21:12] pick an entry, and that entry's low ten bits become the physical page number. The 12-bit offset within the page is kept as it is. Any address at or above 0x400000 passes through unchanged.

Each translation is a two-clock read-modify-write on the entry it used. In the first clock the entry is read. In the second clock the physical address is formed, and the entry's usage field is written back when that field is nonzero:

- a read marks the page as accessed;
- a write marks it as accessed and dirty.

The CPU reads and writes the table, one 16-bit word at a time, through a window. The window repeats every 2 KB across a 64 KB zone.

The block sits between the CPU address path and the RAM controller. It raises `req_ready` whenever it can take a new request. It pulses `xl_done` with the physical address one clock after the lookup.

Top module: `page_xlat`

## Requirements
- R1: A request whose address has any of bits [23:22] set produces `xl_addr` equal to the request address, and the table is left unmodified.
- R2: For an address below 0x400000, `xl_addr` is {2'b00, entry[9:0], addr[11:0]}, where the entry is the one indexed by addr[21:12].
- R3: A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low for the single cycle after acceptance. `xl_done` is high for exactly one cycle, starting at the second edge after acceptance.
- R4: If the entry's status field, bits [14:13], is 00, a translation leaves the entry unchanged.
- R5: A read translation through an entry whose status field is nonzero sets bit 14 of that entry. All other bits are kept.
- R6: A write translation through an entry whose status field is nonzero sets bits 14 and 13 of that entry. All other bits are kept.
- R7: A window access addresses entry `map_addr[10:1]`, so the upper zone bits and bit 0 are ignored. A window write stores `map_wdata` whole. A window read presents the entry on `map_rdata` one cycle later.
- R8: A window write in the same cycle as a status write-back wins, and the status update is discarded.
- R9: A lookup sees the table contents as they were before any window write made on the same clock edge.
- R10: During reset, `req_ready` is 1, `xl_done` is 0 and `xl_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_addr | input | 24 | Logical address |
| req_ready | output | 1 | Block can accept a request |
| xl_done | output | 1 | One-cycle pulse: `xl_addr` is valid |
| xl_addr | output | 24 | Physical address |
| map_sel | input | 1 | Table window access this cycle |
| map_we | input | 1 | 1 = window write, 0 = window read |
| map_addr | input | 16 | Byte offset within the window zone |
| map_wdata | input | 16 | Entry value to store |
| map_rdata | output | 16 | Entry value read through the window |

## Verification
A corrupted table entry shows up in one of two places: at the next translation through that page, as a wrong page number in `xl_addr`, or at the next window read of that entry, as wrong status or page bits. Either appears one clock after the access. A stuck or lost busy flag shows at once: `req_ready` holds low, or a second acceptance comes too early, and `xl_done` is missing or appears out of place two edges after acceptance. The bench compares every port against its reference on every cycle, so any of these appears within the cycle after its cause.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
    localparam int ENT_W   = 16;
    localparam int ST_HI   = 14;   // accessed mark
    localparam int ST_LO   = 13;   // dirty mark
    typedef logic [ENT_W-1:0] map_entry_t;

    localparam map_entry_t MARK_RD = map_entry_t'(1) << ST_HI;
    localparam map_entry_t MARK_WR = (map_entry_t'(1) << ST_HI) | (map_entry_t'(1) << ST_LO);
endpackage

// File: rtl/map_ram.sv
module map_ram
    import xlat_pkg::*;
#(
    parameter int IDX_W   = 10,
    parameter int ZONE_AW = 16
) (
    input  logic               clk,
    input  logic               lk_en,
    input  logic [IDX_W-1:0]   lk_idx,
    output map_entry_t         lk_data,
    input  logic               wb_en,
    input  logic [IDX_W-1:0]   wb_idx,
    input  map_entry_t         wb_data,
    input  logic               cpu_sel,
    input  logic               cpu_we,
    input  logic [ZONE_AW-1:0] cpu_addr,
    input  map_entry_t         cpu_wdata,
    output map_entry_t         cpu_rdata
);
    localparam int DEPTH = 1 << IDX_W;

    map_entry_t mem [DEPTH];
    map_entry_t lk_q, rd_q;
    logic [IDX_W-1:0] cpu_idx;
    logic unused_abits;

    // window repeats every 2**(IDX_W+1) bytes; bit 0 selects nothing (word access)
    assign cpu_idx     = cpu_addr[IDX_W:1];
    assign unused_abits = ^{cpu_addr[ZONE_AW-1:IDX_W+1], cpu_addr[0]};

    // reads take the value before any write on the same edge
    always_ff @(posedge clk) begin
        if (lk_en)
            lk_q <= mem[lk_idx];
        if (cpu_sel && !cpu_we)
            rd_q <= mem[cpu_idx];
        if (cpu_sel && cpu_we)
            mem[cpu_idx] <= cpu_wdata;
        else if (wb_en)
            mem[wb_idx] <= wb_data;
    end

    assign lk_data   = lk_q;
    assign cpu_rdata = rd_q;
endmodule

// File: rtl/xlat_core.sv
module xlat_core
    import xlat_pkg::*;
#(
    parameter int LA_W  = 24,
    parameter int IDX_W = 10,
    parameter int OFF_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [LA_W-1:0]  req_addr,
    output logic             req_ready,
    output logic             xl_done,
    output logic [LA_W-1:0]  xl_addr,
    output logic             lk_en,
    output logic [IDX_W-1:0] lk_idx,
    input  map_entry_t       lk_data,
    output logic             wb_en,
    output logic [IDX_W-1:0] wb_idx,
    output map_entry_t       wb_data
);
    localparam int PA_W = IDX_W + OFF_W;

    typedef struct packed {
        logic            busy;
        logic            wr;
        logic [LA_W-1:0] laddr;
        logic            done;
        logic [LA_W-1:0] paddr;
    } core_st_t;

    core_st_t st_d, st_q;
    logic     in_ram;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        in_ram    = ~|st_q.laddr[LA_W-1:PA_W];
        lk_en     = req_valid && !st_q.busy;
        lk_idx    = req_addr[OFF_W +: IDX_W];
        wb_en     = 1'b0;
        wb_idx    = st_q.laddr[OFF_W +: IDX_W];
        wb_data   = lk_data | (st_q.wr ? MARK_WR : MARK_RD);

        // second clock: form the address and mark the entry
        if (st_q.busy) begin
            st_d.busy = 1'b0;
            st_d.done = 1'b1;
            if (in_ram) begin
                st_d.paddr             = '0;
                st_d.paddr[PA_W-1:0]   = {lk_data[IDX_W-1:0], st_q.laddr[OFF_W-1:0]};
                wb_en                  = |lk_data[ST_HI:ST_LO];
            end else begin
                st_d.paddr = st_q.laddr;
            end
        end

        // first clock: capture request, table read issued
        if (lk_en) begin
            st_d.busy  = 1'b1;
            st_d.wr    = req_write;
            st_d.laddr = req_addr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign req_ready = !st_q.busy;
    assign xl_done   = st_q.done;
    assign xl_addr   = st_q.paddr;
endmodule

// File: rtl/page_xlat.sv
module page_xlat
    import xlat_pkg::*;
#(
    parameter int LA_W    = 24,
    parameter int IDX_W   = 10,
    parameter int OFF_W   = 12,
    parameter int ZONE_AW = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [LA_W-1:0]    req_addr,
    output logic               req_ready,
    output logic               xl_done,
    output logic [LA_W-1:0]    xl_addr,
    input  logic               map_sel,
    input  logic               map_we,
    input  logic [ZONE_AW-1:0] map_addr,
    input  logic [ENT_W-1:0]   map_wdata,
    output logic [ENT_W-1:0]   map_rdata
);
    logic             lk_en, wb_en;
    logic [IDX_W-1:0] lk_idx, wb_idx;
    map_entry_t       lk_data, wb_data;

    xlat_core #(.LA_W(LA_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_ready (req_ready),
        .xl_done   (xl_done),
        .xl_addr   (xl_addr),
        .lk_en     (lk_en),
        .lk_idx    (lk_idx),
        .lk_data   (lk_data),
        .wb_en     (wb_en),
        .wb_idx    (wb_idx),
        .wb_data   (wb_data)
    );

    map_ram #(.IDX_W(IDX_W), .ZONE_AW(ZONE_AW)) u_ram (
        .clk       (clk),
        .lk_en     (lk_en),
        .lk_idx    (lk_idx),
        .lk_data   (lk_data),
        .wb_en     (wb_en),
        .wb_idx    (wb_idx),
        .wb_data   (wb_data),
        .cpu_sel   (map_sel),
        .cpu_we    (map_we),
        .cpu_addr  (map_addr),
        .cpu_wdata (map_wdata),
        .cpu_rdata (map_rdata)
    );
endmodule

// File: rtl/xlat_chk.sv
module xlat_chk #(
    parameter int LA_W  = 24,
    parameter int IDX_W = 10,
    parameter int OFF_W = 12
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic [LA_W-1:0] req_addr,
    input logic            req_ready,
    input logic            xl_done,
    input logic [LA_W-1:0] xl_addr
);
    localparam int PA_W = IDX_W + OFF_W;

    p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        xl_done |=> !xl_done);

    p_busy_after_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    p_done_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |-> ##2 xl_done);

    p_passthrough_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && (req_addr[LA_W-1:PA_W] != '0))
            |-> ##2 (xl_addr == $past(req_addr, 2)));

    p_offset_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready)
            |-> ##2 (xl_addr[OFF_W-1:0] == $past(req_addr[OFF_W-1:0], 2)));

    p_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && (req_addr[LA_W-1:PA_W] == '0))
            |-> ##2 (xl_addr[LA_W-1:PA_W] == '0));
endmodule

bind page_xlat xlat_chk #(.LA_W(LA_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .req_ready (req_ready),
    .xl_done   (xl_done),
    .xl_addr   (xl_addr)
);

// File: tb/page_xlat_bench.sv
module page_xlat_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [23:0] req_addr = '0;
    logic        req_ready, xl_done;
    logic [23:0] xl_addr;
    logic        map_sel = 1'b0, map_we = 1'b0;
    logic [15:0] map_addr = '0, map_wdata = '0;
    logic [15:0] map_rdata;

    always #10 clk = ~clk;   // 50 MHz

    page_xlat u_page_xlat (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_ready(req_ready), .xl_done(xl_done), .xl_addr(xl_addr),
        .map_sel(map_sel), .map_we(map_we), .map_addr(map_addr),
        .map_wdata(map_wdata), .map_rdata(map_rdata)
    );

    int    checks = 0, errors = 0;
    string phase = "R10";
    bit    finished = 0;

    // reference model
    logic [15:0] mdl [1024];
    bit          m_busy = 0, m_wr = 0;
    logic [23:0] m_addr = '0;
    logic [15:0] m_ent = '0;
    bit          e_done = 0, e_ready = 1, e_rv = 0;
    logic [23:0] e_paddr = '0;
    logic [15:0] e_rdata = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; e_done = 0; e_ready = 1; e_rv = 0; e_paddr = '0;
        end else begin
            int          ci, wi;
            bit          acc, wb;
            logic [15:0] wbd;
            ci = int'(map_addr[10:1]);
            wi = 0; wb = 0; wbd = '0;
            e_rv = map_sel && !map_we;
            if (e_rv) e_rdata = mdl[ci];
            e_done = m_busy;
            if (m_busy) begin
                if (m_addr < 24'h400000) begin
                    e_paddr = {2'b00, m_ent[9:0], m_addr[11:0]};
                    if (m_ent[14:13] != 2'b00) begin
                        wb  = 1;
                        wbd = m_ent | (m_wr ? 16'h6000 : 16'h4000);
                        wi  = int'(m_addr[21:12]);
                    end
                end else begin
                    e_paddr = m_addr;
                end
            end
            acc = req_valid && !m_busy;
            if (acc) begin
                m_ent  = mdl[int'(req_addr[21:12])];
                m_wr   = req_write;
                m_addr = req_addr;
            end
            if (map_sel && map_we) mdl[ci] = map_wdata;
            else if (wb)           mdl[wi] = wbd;
            m_busy  = acc;
            e_ready = !acc;
        end
    end

    task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", phase, what, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk(req_ready === e_ready, "ready", 32'(req_ready), 32'(e_ready));
            chk(xl_done === e_done, "done", 32'(xl_done), 32'(e_done));
            if (e_done) chk(xl_addr === e_paddr, "xl_addr", 32'(xl_addr), 32'(e_paddr));
            if (e_rv) chk(map_rdata === e_rdata, "map_rdata", 32'(map_rdata), 32'(e_rdata));
        end
    end

    task automatic win_wr(input logic [15:0] a, input logic [15:0] d);
        @(negedge clk);
        map_sel = 1; map_we = 1; map_addr = a; map_wdata = d;
        @(negedge clk);
        map_sel = 0; map_we = 0;
    endtask

    task automatic win_rd(input logic [15:0] a, input logic [15:0] exp, input string what);
        @(negedge clk);
        map_sel = 1; map_we = 0; map_addr = a;
        @(negedge clk);
        map_sel = 0;
        chk(map_rdata === exp, what, 32'(map_rdata), 32'(exp));
    endtask

    task automatic xlate(input logic [23:0] a, input bit w, input logic [23:0] exp, input string what);
        @(negedge clk);
        req_valid = 1; req_write = w; req_addr = a;
        @(negedge clk);
        req_valid = 0;
        @(negedge clk);
        chk(xl_done === 1'b1, {what, " done"}, 32'(xl_done), 32'd1);
        chk(xl_addr === exp, what, 32'(xl_addr), 32'(exp));
    endtask

    task automatic summary();
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected completion");
            summary();
        end
    end

    initial begin
        // R10 reset values
        repeat (3) @(negedge clk);
        chk(req_ready === 1'b1, "reset ready", 32'(req_ready), 32'd1);
        chk(xl_done === 1'b0, "reset done", 32'(xl_done), 32'd0);
        chk(xl_addr === 24'h0, "reset xl_addr", 32'(xl_addr), 32'd0);
        rst_n = 1;

        // R7 window writes, one through a mirror alias
        phase = "R7";
        win_wr(16'h0002, 16'h0123);          // entry 1, status 00
        win_wr(16'h0004, 16'h22AA);          // entry 2, status 01
        win_wr(16'h0006, 16'h4055);          // entry 3, status 10
        win_wr(16'hF80A, 16'h4077);          // entry 5 via alias
        win_wr(16'h000C, 16'h0066);          // entry 6, status 00
        win_rd(16'h000A, 16'h4077, "mirror read entry5");
        win_rd(16'h0805, 16'h22AA, "alias bit0 read entry2");

        // R2 / R4 status zero
        phase = "R2";
        xlate(24'h001ABC, 0, 24'h123ABC, "map page1");
        phase = "R4";
        win_rd(16'h0002, 16'h0123, "entry1 unchanged");

        // R5 read mark
        phase = "R5";
        xlate(24'h002010, 0, 24'h2AA010, "map page2");
        win_rd(16'h0004, 16'h62AA, "entry2 accessed");

        // R1 pass-through leaves entry3 alone
        phase = "R1";
        xlate(24'h403000, 1, 24'h403000, "pass low io");
        xlate(24'hFFFFFF, 0, 24'hFFFFFF, "pass top");
        win_rd(16'h0006, 16'h4055, "entry3 untouched");

        // R6 write mark
        phase = "R6";
        xlate(24'h003FFF, 1, 24'h055FFF, "map page3");
        win_rd(16'h0006, 16'h6055, "entry3 dirty");

        // R8 window write during write-back wins
        phase = "R8";
        @(negedge clk);
        req_valid = 1; req_write = 1; req_addr = 24'h005004;
        @(negedge clk);
        req_valid = 0;
        map_sel = 1; map_we = 1; map_addr = 16'h000A; map_wdata = 16'h0011;
        @(negedge clk);
        map_sel = 0; map_we = 0;
        chk(xl_addr === 24'h077004, "xlate uses old entry5", 32'(xl_addr), 32'h077004);
        win_rd(16'h000A, 16'h0011, "entry5 holds window data");

        // R9 lookup reads before same-edge window write
        phase = "R9";
        @(negedge clk);
        req_valid = 1; req_write = 0; req_addr = 24'h006100;
        map_sel = 1; map_we = 1; map_addr = 16'h000C; map_wdata = 16'h00EE;
        @(negedge clk);
        req_valid = 0; map_sel = 0; map_we = 0;
        @(negedge clk);
        chk(xl_addr === 24'h066100, "lookup old entry6", 32'(xl_addr), 32'h066100);
        win_rd(16'h000C, 16'h00EE, "entry6 new value");

        // R3 back-to-back valid: accepted every other cycle
        phase = "R3";
        @(negedge clk);
        req_valid = 1; req_write = 0; req_addr = 24'h002000;
        @(negedge clk);
        chk(req_ready === 1'b0, "ready low after accept", 32'(req_ready), 32'd0);
        repeat (6) @(negedge clk);
        req_valid = 0;
        repeat (3) @(negedge clk);
        chk(req_ready === 1'b1, "ready idle", 32'(req_ready), 32'd1);

        summary();
    end
endmodule